// File: doc/BRIEF.md
# Transmit Interrupt Pin Generator with RS-485 Turnaround Mode

This block drives the transmitter's share of a UART channel's interrupt pin. It holds the outgoing characters and serialises them, and it decides from the transmit path state whether the pin is high (asking for data) or low. Characters arrive through a write strobe. The storage is either a single holding register or a 128-entry FIFO. A shift model takes the oldest character whenever it is idle. It then frames the character and shifts it out, one bit per bit-clock strobe, for a parameterised number of strobes.

In holding-register mode the pin reports whether the holding register is free. In FIFO mode it compares the FIFO level against a programmable trigger level. The RS-485 option is meant for half-duplex links, where the line driver may only be turned around once the last stop bit has left the wire. With that option on, the "empty" condition becomes transmitter-empty, which means the storage is empty and the shifter is idle.

Top module: `tx_irq_gen`

## Requirements
- R1: After reset the storage is empty, the shifter is idle, `tx_o` is 1 and `irq_o` is 1.
- R2: With `fifo_en_i`=0 and `rs485_en_i`=0, `irq_o` is 0 while the holding register holds a character. It is 1 once the holding register is empty, even while the shifter is still sending.
- R3: With `fifo_en_i`=0 and `rs485_en_i`=1, `irq_o` is 0 while the holding register is occupied or the shifter is busy. It becomes 1 only when both are idle.
- R4: With `fifo_en_i`=1 and `rs485_en_i`=0, `irq_o` is 0 when the FIFO level is greater than `trig_lvl_i`. It is 1 when the level is less than or equal to `trig_lvl_i`.
- R5: With `fifo_en_i`=1 and `rs485_en_i`=1, `irq_o` is 1 when the level is below `trig_lvl_i` or when the FIFO and the shifter are both empty. It is 0 otherwise, and a level equal to the trigger counts as 0.
- R6: The storage holds 128 characters in FIFO mode and 1 in holding mode. A write made when the storage is full and no character leaves in the same cycle is discarded.
- R7: The shifter loads the oldest stored character on the clock edge after it is idle with data available. It stays busy for exactly BITS_PER_CHAR strobes of `bit_tick_i`. The frame sent on `tx_o` is one start bit of 0, then the data LSB first, then stop bits of 1. `tx_o` is 1 when the shifter is idle.
- R8: A change of `fifo_en_i` discards every stored character on the next clock edge. A character already in the shifter still completes.
- R9: Characters leave the shifter in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for one character |
| wr_data_i | input | DATA_W | Character to store |
| bit_tick_i | input | 1 | One-cycle bit-clock strobe for the shifter |
| fifo_en_i | input | 1 | 1 selects FIFO storage, 0 selects the single holding register |
| rs485_en_i | input | 1 | 1 selects transmitter-empty semantics |
| trig_lvl_i | input | LVL_W | Transmit trigger level |
| tx_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Transmitter interrupt pin level |

## Verification
A write is counted in the level on the rising edge where `wr_i` is high, so the pin shows it right after that edge. The shifter takes the character one edge later. Busy clears on the edge of the BITS_PER_CHAR-th strobe, and the pin follows that same edge. A change of the trigger or mode inputs reaches the pin without any register. The bench drives and samples only at falling edges, and waits exactly the count of edges above before each check. A trigger change is checked 1 ns after it is applied, with no edge in between.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_HOLD_485 = 2'b01,
    MODE_FIFO     = 2'b10,
    MODE_FIFO_485 = 2'b11
  } irq_mode_e;

  function automatic irq_mode_e pick_mode(input logic fifo_en, input logic rs485_en);
    return irq_mode_e'({fifo_en, rs485_en});
  endfunction

endpackage

// File: rtl/tx_store.sv
module tx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LW-1:0]     level_o,
  output logic              avail_o,
  output logic              flush_o
);

  localparam logic [LW-1:0] CAP_FIFO = LW'(DEPTH);
  localparam logic [LW-1:0] CAP_HOLD = LW'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [LW-1:0]     cnt;
  logic              en_q;
  logic [LW-1:0]     cap;
  logic              push_ok, pop_ok;

  // mode change empties the storage
  assign flush_o = (en_q != fifo_en_i);
  assign cap     = fifo_en_i ? CAP_FIFO : CAP_HOLD;
  assign avail_o = (cnt != '0) && !flush_o;
  assign pop_ok  = pop_i && avail_o;
  assign push_ok = push_i && !flush_o && ((cnt < cap) || pop_ok);
  assign data_o  = mem[rptr];
  assign level_o = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      en_q <= fifo_en_i;
      if (flush_o) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        if (push_ok) wptr <= wptr + AW'(1);
        if (pop_ok)  rptr <= rptr + AW'(1);
        unique case ({push_ok, pop_ok})
          2'b10:   cnt <= cnt + LW'(1);
          2'b01:   cnt <= cnt - LW'(1);
          default: cnt <= cnt;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr] <= data_i;
  end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int DATA_W = 8,
  parameter int BITS   = 10,
  localparam int CW    = $clog2(BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              tx_o
);

  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] sh;
  logic            load;

  assign load   = !busy && avail_i;
  assign pop_o  = load;
  assign busy_o = busy;
  assign tx_o   = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '1;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      sh   <= {{(BITS-DATA_W-1){1'b1}}, data_i, 1'b0};
    end else if (busy && tick_i) begin
      sh <= {1'b1, sh[BITS-1:1]};
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/tx_irq_logic.sv
module tx_irq_logic
  import tx_irq_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          fifo_en_i,
  input  logic          rs485_en_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] trig_i,
  input  logic          busy_i,
  output logic          irq_o
);

  irq_mode_e mode;
  logic      store_empty, xmit_empty;

  assign mode        = pick_mode(fifo_en_i, rs485_en_i);
  assign store_empty = (level_i == '0);
  assign xmit_empty  = store_empty && !busy_i;

  always_comb begin
    unique case (mode)
      MODE_HOLD:     irq_o = store_empty;
      MODE_HOLD_485: irq_o = xmit_empty;
      MODE_FIFO:     irq_o = (level_i <= trig_i);
      MODE_FIFO_485: irq_o = (level_i < trig_i) || xmit_empty;
      default:       irq_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/tx_irq_gen.sv
module tx_irq_gen #(
  parameter int  DATA_W        = 8,
  parameter int  FIFO_DEPTH    = 128,
  parameter int  BITS_PER_CHAR = 10,
  localparam int LVL_W         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_tick_i,
  input  logic              fifo_en_i,
  input  logic              rs485_en_i,
  input  logic [LVL_W-1:0]  trig_lvl_i,
  output logic              tx_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] head;
  logic [LVL_W-1:0]  level;
  logic              avail, pop, busy, flush;

  tx_store #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fifo_en_i(fifo_en_i),
    .push_i   (wr_i),
    .data_i   (wr_data_i),
    .pop_i    (pop),
    .data_o   (head),
    .level_o  (level),
    .avail_o  (avail),
    .flush_o  (flush)
  );

  tx_shifter #(.DATA_W(DATA_W), .BITS(BITS_PER_CHAR)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .avail_i(avail),
    .data_i (head),
    .tick_i (bit_tick_i),
    .pop_o  (pop),
    .busy_o (busy),
    .tx_o   (tx_o)
  );

  tx_irq_logic #(.LW(LVL_W)) u_irq (
    .fifo_en_i (fifo_en_i),
    .rs485_en_i(rs485_en_i),
    .level_i   (level),
    .trig_i    (trig_lvl_i),
    .busy_i    (busy),
    .irq_o     (irq_o)
  );

endmodule

// File: rtl/tx_irq_gen_chk.sv
module tx_irq_gen_chk #(
  parameter int DEPTH = 128,
  parameter int LW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          rs485_en_i,
  input logic [LW-1:0] trig_i,
  input logic [LW-1:0] level_i,
  input logic          busy_i,
  input logic          flush_i,
  input logic          irq_i,
  input logic          tx_i
);

  AST_IDLE_PATH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0 && !busy_i) |-> irq_i); // R5

  AST_HOLD_FULL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && level_i != '0) |-> !irq_i); // R2

  AST_RS485_BUSY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && rs485_en_i && busy_i) |-> !irq_i); // R3

  AST_ABOVE_TRIG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && level_i > trig_i) |-> !irq_i); // R4

  AST_LEVEL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (level_i <= (fifo_en_i ? LW'(DEPTH) : LW'(1)))); // R6

  AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != '0 && !busy_i && !flush_i) |=> busy_i); // R7

  AST_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> tx_i); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_i == '0)); // R8

endmodule

bind tx_irq_gen tx_irq_gen_chk #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fifo_en_i (fifo_en_i),
  .rs485_en_i(rs485_en_i),
  .trig_i    (trig_lvl_i),
  .level_i   (level),
  .busy_i    (busy),
  .flush_i   (flush),
  .irq_i     (irq_o),
  .tx_i      (tx_o)
);

// File: tb/tx_irq_gen_bench.sv
module tx_irq_gen_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 128;
  localparam int BITS  = 10;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr = 1'b0, tick = 1'b0, fifo_en = 1'b0, rs485 = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [LW-1:0] trig = '0;
  logic          tx, irq;
  logic [BITS-1:0] f;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tx_irq_gen #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .BITS_PER_CHAR(BITS)) u_tx_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata), .bit_tick_i(tick),
    .fifo_en_i(fifo_en), .rs485_en_i(rs485), .trig_lvl_i(trig), .tx_o(tx), .irq_o(irq)
  );

  function automatic logic [BITS-1:0] framed(input logic [DW-1:0] d);
    return {{(BITS-DW-1){1'b1}}, d, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [DW-1:0] d);
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic shift_char(output logic [BITS-1:0] fr);
    for (int i = 0; i < BITS; i++) begin
      fr[i] = tx; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_ticks(input int n);
    repeat (n) begin tick = 1'b1; @(negedge clk); tick = 1'b0; end
  endtask

  task automatic quiet_line(input string req);
    int bad = 0;
    for (int i = 0; i < BITS; i++) begin
      if (tx !== 1'b1) bad++;
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_reset;
    chk("R1 irq during reset", int'(irq), 1);
    rst_n = 1'b1;
    step(1);
    chk("R1 irq after reset", int'(irq), 1);
    chk("R1 tx idle after reset", int'(tx), 1);
  endtask

  task automatic t_hold_plain;
    fifo_en = 1'b0; rs485 = 1'b0;
    put(8'hA5);
    chk("R2 irq low with byte held", int'(irq), 0);
    step(1);
    chk("R2 irq high while shifting", int'(irq), 1);
    chk("R7 start bit", int'(tx), 0);
    put(8'h11);
    chk("R2 irq low on refill", int'(irq), 0);
    put(8'h22);
    shift_char(f);
    chk("R7 frame A5", int'(f), int'(framed(8'hA5)));
    chk("R2 irq low, holding still full", int'(irq), 0);
    step(1);
    shift_char(f);
    chk("R6 held byte kept", int'(f), int'(framed(8'h11)));
    step(1);
    quiet_line("R6 overflow write dropped");
    chk("R2 irq high when empty", int'(irq), 1);
  endtask

  task automatic t_hold_485;
    rs485 = 1'b1;
    put(8'h3C);
    chk("R3 irq low with byte held", int'(irq), 0);
    step(1);
    chk("R3 irq low while shifting", int'(irq), 0);
    pulse_ticks(BITS - 1);
    chk("R3 irq low before last bit", int'(irq), 0);
    pulse_ticks(1);
    chk("R3 irq high after last bit", int'(irq), 1);
  endtask

  task automatic t_fifo_plain;
    fifo_en = 1'b1; rs485 = 1'b0; trig = LW'(2);
    step(2);
    put(8'h01);
    step(1);
    put(8'h02);
    chk("R4 level 1 trig 2", int'(irq), 1);
    put(8'h03);
    chk("R4 level equal trig", int'(irq), 1);
    put(8'h04);
    chk("R4 level above trig", int'(irq), 0);
    trig = LW'(3); #1;
    chk("R4 raised trig", int'(irq), 1);
  endtask

  task automatic t_fifo_485;
    rs485 = 1'b1; #1;
    chk("R5 level equal trig", int'(irq), 0);
    trig = LW'(4); #1;
    chk("R5 level below trig", int'(irq), 1);
    trig = LW'(0); #1;
    chk("R5 trig 0 with data", int'(irq), 0);
    shift_char(f);
    chk("R9 first out", int'(f), int'(framed(8'h01)));
    step(1);
    shift_char(f);
    chk("R9 second out", int'(f), int'(framed(8'h02)));
    step(1);
    shift_char(f);
    chk("R9 third out", int'(f), int'(framed(8'h03)));
    step(1);
    chk("R5 fifo empty but shifting", int'(irq), 0);
    shift_char(f);
    chk("R9 fourth out", int'(f), int'(framed(8'h04)));
    chk("R5 transmitter empty", int'(irq), 1);
  endtask

  task automatic t_capacity;
    int bad = 0;
    rs485 = 1'b0; trig = LW'(127);
    for (int i = 0; i < 130; i++) put(DW'(i));
    chk("R6 level 128 above trig 127", int'(irq), 0);
    trig = LW'(128); #1;
    chk("R6 level 128 equal trig", int'(irq), 1);
    for (int i = 0; i < 129; i++) begin
      shift_char(f);
      if (f !== framed(DW'(i))) bad++;
      step(1);
    end
    chk("R9 order across full fifo", bad, 0);
    quiet_line("R6 write beyond 128 dropped");
    chk("R4 irq high when drained", int'(irq), 1);
  endtask

  task automatic t_flush;
    trig = LW'(0);
    step(1);
    put(8'hA1);
    step(1);
    put(8'hB2);
    put(8'hC3);
    fifo_en = 1'b0;
    step(1);
    chk("R8 storage flushed", int'(irq), 1);
    shift_char(f);
    chk("R8 shifting char completes", int'(f), int'(framed(8'hA1)));
    step(1);
    quiet_line("R8 flushed chars not sent");
  endtask

  initial begin
    step(2);
    t_reset();
    t_hold_plain();
    t_hold_485();
    t_fifo_plain();
    t_fifo_485();
    t_capacity();
    t_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

endmodule